// File: doc/BRIEF.md
# I2C Master Start Reservation Controller

This block sits next to an I2C master/slave engine. It decides what to do when software asks for a start condition. If the bus is idle, it requests a start at once and the device becomes master. If another device holds the bus, the request is parked as a reservation. A parked reservation turns into a start by itself on the first stop condition seen while stop interrupts are enabled.

Address bytes written to the shift register while a reservation is parked are discarded. After a start has been issued, the first write is passed on as the address to send. Each accepted request also loads a wait timer. Its length depends on the clock-mode select inputs. Software reads the master flag once the timer expires to learn whether the start took effect or is still reserved.

Top module: `i2c_start_rsv`

## Requirements
- R1: After reset, `start_gen`, `master_sts`, `rsv_pend`, `addr_load` and `wait_done` are all 0.
- R2: A `start_req` sampled while not master, with no reservation pending and `bus_busy` low, makes `start_gen` 1 for exactly the following cycle and sets `master_sts` in that same cycle.
- R3: A `start_req` sampled while not master, with no reservation pending and `bus_busy` high, sets `rsv_pend`. It does not pulse `start_gen` and leaves `master_sts` at 0.
- R4: When `rsv_pend` is 1 and `stop_det` and `stop_ie` are both 1 at a clock edge, `start_gen` pulses for one cycle. In that same cycle `rsv_pend` drops to 0 and `master_sts` becomes 1.
- R5: A `stop_det` with `stop_ie` low leaves a pending reservation in place and produces no start.
- R6: A `shift_wr` made while a reservation is pending produces no `addr_load`. After a start is issued, the first `shift_wr` produces a one-cycle `addr_load` pulse in the next cycle.
- R7: `rsv_abort` or `slave_addressed` clears a pending reservation, so a later stop produces no start.
- R8: A `start_req` while `master_sts` is 1 is ignored: no `start_gen`.
- R9: `arb_lost` or `ext_release` clears `master_sts`, after which a new request is accepted again.
- R10: The wait timer reloads on each accepted request. `wait_done` rises exactly N clock edges after the accepting edge, where N is chosen by {`hs_sel`,`fm_sel`,`clk_sel`}:
  - `hs_sel`=0, `fm_sel`=0: `clk_sel` 0/1/2/3 gives 46/86/172/34.
  - `hs_sel`=0, `fm_sel`=1: `clk_sel` 0/1/2/3 gives 30/60/12/18.
  - `hs_sel`=1 (any `fm_sel`): `clk_sel` 0/1/2/3 gives 12/18/36/36.
- R11: `stop_det` clears `master_sts` when no reservation fires on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Software start request strobe |
| bus_busy | input | 1 | Bus currently held by a transfer |
| stop_det | input | 1 | Stop condition detected |
| stop_ie | input | 1 | Stop interrupt enable |
| arb_lost | input | 1 | Arbitration lost, device is neither master nor slave |
| ext_release | input | 1 | Extension code received and slave operation released |
| slave_addressed | input | 1 | Device matched as slave |
| rsv_abort | input | 1 | Software cancel of reservation |
| shift_wr | input | 1 | Write strobe into the shift register |
| hs_sel | input | 1 | High-speed clock select |
| fm_sel | input | 1 | Fast-mode select |
| clk_sel | input | 2 | Clock divider select |
| start_gen | output | 1 | One-cycle start generate pulse |
| master_sts | output | 1 | Device is master |
| rsv_pend | output | 1 | Reservation pending |
| addr_load | output | 1 | One-cycle pulse: shift-register byte is a valid address |
| wait_done | output | 1 | Wait period expired |

## Verification
The bench writes an address while a reservation is pending and checks that `addr_load` stays low. A design that kept that stale byte would send it after the stop.

It raises a stop with the interrupt disabled and expects the reservation to survive. A design that fires without the enable would start early; one that drops the reservation would lose the request.

It issues a second request while master, which catches a double start. It cancels a reservation through both the abort input and the slave-match input, then confirms that no start appears on the later stop.

Wait lengths are counted edge by edge in several clock modes. This exposes an off-by-one counter or a swapped table entry.

// File: rtl/i2c_rsv_pkg.sv
package i2c_rsv_pkg;

    localparam int CNT_W = 8;

    typedef struct packed {
        logic master;
        logic pend;
        logic start;
        logic armed;
        logic addr_ld;
    } ctrl_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } tmr_st_t;

    function automatic logic [CNT_W-1:0] wait_len(input logic hs, input logic fm,
                                                  input logic [1:0] cs);
        logic [CNT_W-1:0] v;
        if (hs) begin
            case (cs)
                2'd0:    v = CNT_W'(12);
                2'd1:    v = CNT_W'(18);
                default: v = CNT_W'(36);
            endcase
        end else if (fm) begin
            case (cs)
                2'd0:    v = CNT_W'(30);
                2'd1:    v = CNT_W'(60);
                2'd2:    v = CNT_W'(12);
                default: v = CNT_W'(18);
            endcase
        end else begin
            case (cs)
                2'd0:    v = CNT_W'(46);
                2'd1:    v = CNT_W'(86);
                2'd2:    v = CNT_W'(172);
                default: v = CNT_W'(34);
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/i2c_rsv_timer.sv
module i2c_rsv_timer
    import i2c_rsv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt  = load_val;
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;

    // R10
    done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.cnt == '0));

    // R10
    busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !st_q.done);

    // R10
    done_after_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(st_q.cnt) == CNT_W'(1));

endmodule

// File: rtl/i2c_rsv_ctrl.sv
module i2c_rsv_ctrl
    import i2c_rsv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic bus_busy,
    input  logic stop_det,
    input  logic stop_ie,
    input  logic arb_lost,
    input  logic ext_release,
    input  logic slave_addressed,
    input  logic rsv_abort,
    input  logic shift_wr,
    output logic accept,
    output logic start_gen,
    output logic master_sts,
    output logic rsv_pend,
    output logic addr_load
);

    ctrl_st_t st_d, st_q;
    logic     cancel;
    logic     fire;

    always_comb begin
        cancel = st_q.pend && (rsv_abort || slave_addressed);
        fire   = st_q.pend && stop_det && stop_ie && !cancel;
        accept = start_req && !st_q.master && !st_q.pend;

        st_d         = st_q;
        st_d.start   = 1'b0;
        st_d.addr_ld = 1'b0;

        if (arb_lost || ext_release || stop_det) begin
            st_d.master = 1'b0;
            st_d.armed  = 1'b0;
        end
        if (cancel) st_d.pend = 1'b0;

        if (st_q.armed && shift_wr && !fire) begin
            st_d.addr_ld = 1'b1;
            st_d.armed   = 1'b0;
        end

        if (fire) begin
            st_d.pend   = 1'b0;
            st_d.start  = 1'b1;
            st_d.master = 1'b1;
            st_d.armed  = 1'b1;
        end else if (accept) begin
            if (!bus_busy) begin
                st_d.start  = 1'b1;
                st_d.master = 1'b1;
                st_d.armed  = 1'b1;
            end else begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_gen  = st_q.start;
    assign master_sts = st_q.master;
    assign rsv_pend   = st_q.pend;
    assign addr_load  = st_q.addr_ld;

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_gen |=> !start_gen);

    // R4
    pend_clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_gen && rsv_pend));

    // R3
    pend_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsv_pend) |-> $past(bus_busy));

    // R2
    master_via_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_sts) |-> start_gen);

    // R6
    no_addr_while_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rsv_pend) |-> !addr_load);

endmodule

// File: rtl/i2c_start_rsv.sv
module i2c_start_rsv
    import i2c_rsv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       bus_busy,
    input  logic       stop_det,
    input  logic       stop_ie,
    input  logic       arb_lost,
    input  logic       ext_release,
    input  logic       slave_addressed,
    input  logic       rsv_abort,
    input  logic       shift_wr,
    input  logic       hs_sel,
    input  logic       fm_sel,
    input  logic [1:0] clk_sel,
    output logic       start_gen,
    output logic       master_sts,
    output logic       rsv_pend,
    output logic       addr_load,
    output logic       wait_done
);

    logic             accept;
    logic [CNT_W-1:0] wait_val;

    assign wait_val = wait_len(hs_sel, fm_sel, clk_sel);

    i2c_rsv_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_req       (start_req),
        .bus_busy        (bus_busy),
        .stop_det        (stop_det),
        .stop_ie         (stop_ie),
        .arb_lost        (arb_lost),
        .ext_release     (ext_release),
        .slave_addressed (slave_addressed),
        .rsv_abort       (rsv_abort),
        .shift_wr        (shift_wr),
        .accept          (accept),
        .start_gen       (start_gen),
        .master_sts      (master_sts),
        .rsv_pend        (rsv_pend),
        .addr_load       (addr_load)
    );

    i2c_rsv_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_val),
        .done     (wait_done)
    );

    // R8
    no_start_while_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sts && start_req && !stop_det && !arb_lost && !ext_release) |=> !start_gen);

endmodule

// File: tb/i2c_start_rsv_bench.sv
module i2c_start_rsv_bench;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 0, bus_busy = 0, stop_det = 0, stop_ie = 0;
    logic arb_lost = 0, ext_release = 0, slave_addressed = 0, rsv_abort = 0;
    logic shift_wr = 0, hs_sel = 0, fm_sel = 0;
    logic [1:0] clk_sel = 2'd0;
    logic start_gen, master_sts, rsv_pend, addr_load, wait_done;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_start_rsv u_i2c_start_rsv (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .bus_busy(bus_busy),
        .stop_det(stop_det), .stop_ie(stop_ie), .arb_lost(arb_lost),
        .ext_release(ext_release), .slave_addressed(slave_addressed),
        .rsv_abort(rsv_abort), .shift_wr(shift_wr), .hs_sel(hs_sel),
        .fm_sel(fm_sel), .clk_sel(clk_sel), .start_gen(start_gen),
        .master_sts(master_sts), .rsv_pend(rsv_pend), .addr_load(addr_load),
        .wait_done(wait_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_master();
        stop_det = 1; step(); stop_det = 0; step();
    endtask

    task automatic t_reset();
        chk("R1 start_gen", start_gen, 0);
        chk("R1 master_sts", master_sts, 0);
        chk("R1 rsv_pend", rsv_pend, 0);
        chk("R1 addr_load", addr_load, 0);
        chk("R1 wait_done", wait_done, 0);
    endtask

    task automatic t_free_start();
        bus_busy = 0; start_req = 1; step(); start_req = 0;
        chk("R2 start pulse", start_gen, 1);
        chk("R2 master set", master_sts, 1);
        step();
        chk("R2 start one cycle", start_gen, 0);
        shift_wr = 1; step(); shift_wr = 0;
        chk("R6 addr after start", addr_load, 1);
        step();
        chk("R6 addr one cycle", addr_load, 0);
        start_req = 1; step(); start_req = 0;
        chk("R8 no double start", start_gen, 0);
        stop_det = 1; step(); stop_det = 0;
        chk("R11 stop clears master", master_sts, 0);
    endtask

    task automatic t_reserve();
        bus_busy = 1; stop_ie = 0;
        start_req = 1; step(); start_req = 0;
        chk("R3 pending", rsv_pend, 1);
        chk("R3 no start", start_gen, 0);
        chk("R3 not master", master_sts, 0);
        shift_wr = 1; step(); shift_wr = 0;
        chk("R6 stale write dropped", addr_load, 0);
        stop_det = 1; step(); stop_det = 0;
        chk("R5 still pending", rsv_pend, 1);
        chk("R5 no start", start_gen, 0);
        stop_ie = 1; stop_det = 1; step(); stop_det = 0;
        chk("R4 fire start", start_gen, 1);
        chk("R4 pend cleared", rsv_pend, 0);
        chk("R4 master", master_sts, 1);
        step();
        chk("R4 start one cycle", start_gen, 0);
        chk("R6 no stale load", addr_load, 0);
        shift_wr = 1; step(); shift_wr = 0;
        chk("R6 addr after stop", addr_load, 1);
        arb_lost = 1; step(); arb_lost = 0;
        chk("R9 arb clears master", master_sts, 0);
        bus_busy = 0;
    endtask

    task automatic t_cancel(input bit use_slave);
        bus_busy = 1; stop_ie = 1;
        start_req = 1; step(); start_req = 0;
        chk("R7 pending", rsv_pend, 1);
        if (use_slave) slave_addressed = 1; else rsv_abort = 1;
        step(); slave_addressed = 0; rsv_abort = 0;
        chk("R7 cancelled", rsv_pend, 0);
        stop_det = 1; step(); stop_det = 0;
        chk("R7 no start after cancel", start_gen, 0);
        chk("R7 not master", master_sts, 0);
        bus_busy = 0;
    endtask

    task automatic t_release();
        bus_busy = 0; start_req = 1; step(); start_req = 0;
        chk("R2 master", master_sts, 1);
        ext_release = 1; step(); ext_release = 0;
        chk("R9 ext clears master", master_sts, 0);
        bus_busy = 1; start_req = 1; step(); start_req = 0;
        chk("R9 request accepted again", rsv_pend, 1);
        rsv_abort = 1; step(); rsv_abort = 0; bus_busy = 0;
    endtask

    task automatic t_wait(input bit hs, input bit fm, input logic [1:0] cs, input int n);
        hs_sel = hs; fm_sel = fm; clk_sel = cs; bus_busy = 0;
        start_req = 1; step(); start_req = 0;
        for (int i = 1; i < n; i++) begin
            @(posedge clk);
        end
        @(negedge clk);
        chk($sformatf("R10 not done before %0d", n), wait_done, 0);
        step();
        chk($sformatf("R10 done at %0d", n), wait_done, 1);
        clear_master();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        step();
        t_free_start();
        t_reserve();
        t_cancel(0);
        t_cancel(1);
        t_release();
        t_wait(0, 0, 2'd0, 46);
        t_wait(0, 0, 2'd2, 172);
        t_wait(0, 1, 2'd2, 12);
        t_wait(1, 0, 2'd1, 18);
        t_wait(0, 1, 2'd3, 18);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule